// File: doc/BRIEF.md
# Indirect PHY register access bridge

This block sits between a host register bus and the management port of an internal PHY. The host never addresses PHY registers directly. It programs a command/address word, moves write data through a second word, collects read results from a third, and polls a flag in those words to learn when the PHY access has finished. A fourth word exposes a busy flag. On the PHY side the bridge drives a simple register port with an address, a port number, single-cycle read and write strobes, and write data. Read data comes back a fixed number of cycles after the read strobe.

The two directions use the completion flag in opposite senses. For a read, hardware sets bit 31 of the read-data word once the returned value has been captured. For a write, the host writes the write-data word with bit 31 set to launch the access, and hardware drops that bit once the strobe has been issued. The bridge runs only one PHY access at a time. Host writes that arrive while an access is in flight leave the bridge unchanged.

The host request interface is valid/ready. Ready is tied high, so the bridge never applies back-pressure and every valid cycle is accepted. A read request returns its data on `rsp_valid` in the following cycle. The response has no ready, so the host must take it in that cycle. Write requests produce no response.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset all four host words read as zero, no PHY strobe is driven, `rsp_valid` is low and `req_ready` is high.
- R2: `req_sel` selects the word. 0 is command/address, 1 is write data, 2 is read data, 3 is status. The command/address word holds the register address in bits 15:0, the port in bits 19:16 and the command code in bits 31:20. Once written while idle, it reads back unchanged, and its address and port fields drive `phy_addr` and `phy_port`.
- R3: Writing command code 1 while idle produces exactly one `phy_rd` pulse, in the cycle after the write is accepted.
- R4: The PHY value present RD_LAT cycles after the `phy_rd` cycle is captured at the end of that cycle. From then on the read-data word reads bit 31 = 1 and bits 30:0 = that value zero-extended. Before the capture, bit 31 reads 0.
- R5: Command code 0 only arms a write. The write launches when the write-data word is written with bit 31 set. `phy_wr` then pulses once in the next cycle, with `phy_wdata` equal to bits 15:0 of that word.
- R6: Bit 31 of the write-data word reads 1 while the launched write is pending. It reads 0 from the cycle after the `phy_wr` pulse onward.
- R7: A write-data word with bit 31 clear, or written when no write is armed, starts no access but still updates the stored payload. Each arm allows only one write.
- R8: Every accepted command/address write clears the read-data word, so a stale completion is never seen.
- R9: While an access is in flight, the status word reads bit 0 = 1. Command/address and write-data writes received in that window are ignored: no strobe is issued and no stored value changes.
- R10: A command code other than 0 or 1 is stored and read back. It starts no access and cancels a pending arm.
- R11: A read request accepted in one cycle gives `rsp_valid` high for exactly the next cycle, with the selected word on `rsp_data`. Write requests leave `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request ready (always 1) |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_sel | input | 2 | Word select: 0 cmd/addr, 1 write data, 2 read data, 3 status |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the request |
| rsp_data | output | 32 | Read response data |
| phy_addr | output | ADDR_W | PHY register address |
| phy_port | output | PORT_W | PHY port number |
| phy_wr | output | 1 | PHY write strobe, one cycle |
| phy_wdata | output | DATA_W | PHY write data |
| phy_rd | output | 1 | PHY read strobe, one cycle |
| phy_rdata | input | DATA_W | PHY read data, valid RD_LAT cycles after `phy_rd` |

## Verification
The assertions assume that the PHY model returns data exactly RD_LAT cycles after each read strobe. They also assume the host takes every response in the cycle it appears, since the response path has no way to stall. The stimulus drives a PHY model in the bench with that fixed two-cycle return. Outside the capture cycle the model drives a junk value, so a wrong latency shows up as wrong data. The host side issues back-to-back single-cycle requests, which probe the busy window precisely. Commands that must be ignored are sent inside that window, and their absence of effect is confirmed through strobe monitoring and register readback.

// File: rtl/phyb_pkg.sv
package phyb_pkg;
  localparam int HOST_W   = 32;
  localparam int FLAG_BIT = 31;
  localparam int OP_WRITE = 0;
  localparam int OP_READ  = 1;

  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_RDATA = 2'd2,
    SEL_STAT  = 2'd3
  } phyb_sel_e;
endpackage

// File: rtl/phyb_host_if.sv
module phyb_host_if
  import phyb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  output logic              cmd_we,
  output logic              wdata_we,
  input  logic [HOST_W-1:0] cmd_word,
  input  logic [HOST_W-1:0] wdata_word,
  input  logic [HOST_W-1:0] rdata_word,
  input  logic [HOST_W-1:0] stat_word,
  output logic              rsp_valid,
  output logic [HOST_W-1:0] rsp_data
);
  logic              acc_rd;
  logic [HOST_W-1:0] sel_word;

  // Every offered request is accepted at once.
  assign req_ready = 1'b1;
  assign acc_rd    = req_valid && !req_write;
  assign cmd_we    = req_valid && req_write && (phyb_sel_e'(req_sel) == SEL_CMD);
  assign wdata_we  = req_valid && req_write && (phyb_sel_e'(req_sel) == SEL_WDATA);

  always_comb begin
    case (phyb_sel_e'(req_sel))
      SEL_CMD:   sel_word = cmd_word;
      SEL_WDATA: sel_word = wdata_word;
      SEL_RDATA: sel_word = rdata_word;
      default:   sel_word = stat_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_rd;
      rsp_data  <= acc_rd ? sel_word : '0;
    end
  end

  // R11: a read request is answered in the next cycle, and a write gets no answer.
  a_r11_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r11_no_rsp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);
endmodule

// File: rtl/phyb_cmd_regs.sv
module phyb_cmd_regs
  import phyb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              wdata_we,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              busy,
  output logic [HOST_W-1:0] cmd_word,
  output logic [DATA_W-1:0] payload,
  output logic              start_rd,
  output logic              start_wr,
  output logic              clr_done
);
  localparam int OP_LSB = ADDR_W + PORT_W;
  localparam int OP_W   = HOST_W - OP_LSB;

  logic            armed;
  logic            cmd_ok;
  logic            wd_ok;
  logic [OP_W-1:0] new_op;
  logic            op_is_rd;
  logic            op_is_wr;

  // While an access is in flight, host writes are dropped here.
  assign cmd_ok   = cmd_we && !busy;
  assign wd_ok    = wdata_we && !busy;
  assign new_op   = host_wdata[HOST_W-1:OP_LSB];
  assign op_is_rd = (new_op == OP_W'(OP_READ));
  assign op_is_wr = (new_op == OP_W'(OP_WRITE));

  assign start_rd = cmd_ok && op_is_rd;
  assign start_wr = wd_ok && host_wdata[FLAG_BIT] && armed;
  assign clr_done = cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word <= '0;
      armed    <= 1'b0;
    end else if (cmd_ok) begin
      cmd_word <= host_wdata;
      armed    <= op_is_wr;
    end else if (start_wr) begin
      armed    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     payload <= '0;
    else if (wd_ok) payload <= host_wdata[DATA_W-1:0];
  end

  // R10: an unknown command code leaves nothing armed for the next cycle.
  a_r10_bad_op_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && !op_is_rd && !op_is_wr) |=> !start_wr);
  // R9: a command accepted while busy would be a violation.
  a_r9_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !clr_done);
endmodule

// File: rtl/phyb_xact.sv
module phyb_xact #(
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              clr_done,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              phy_rd,
  output logic              phy_wr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_value,
  output logic              wr_pend,
  output logic              busy
);
  logic [RD_LAT-1:0] rd_pipe;
  logic              rd_active;
  logic              capture;

  assign capture = rd_pipe[RD_LAT-1];
  assign busy    = rd_active || wr_pend;

  // Latency pipe: one stage per cycle between the strobe and valid data.
  generate
    if (RD_LAT == 1) begin : g_lat_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_pipe <= '0;
        else        rd_pipe <= phy_rd;
      end
    end else begin : g_lat_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_pipe <= '0;
        else        rd_pipe <= {rd_pipe[RD_LAT-2:0], phy_rd};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_rd    <= 1'b0;
      phy_wr    <= 1'b0;
      rd_active <= 1'b0;
      wr_pend   <= 1'b0;
    end else begin
      phy_rd <= start_rd;
      phy_wr <= start_wr;
      if (start_rd)     rd_active <= 1'b1;
      else if (capture) rd_active <= 1'b0;
      if (start_wr)     wr_pend <= 1'b1;
      else if (phy_wr)  wr_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done  <= 1'b0;
      rd_value <= '0;
    end else if (clr_done) begin
      rd_done  <= 1'b0;
      rd_value <= '0;
    end else if (capture) begin
      rd_done  <= 1'b1;
      rd_value <= phy_rdata;
    end
  end

  // R3: the read strobe lasts a single cycle.
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rd |=> !phy_rd);
  // R5: read and write strobes never coincide.
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_rd && phy_wr));
  // R6: the pending flag is gone once the write strobe has been issued.
  a_r6_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr |=> !wr_pend);
  // R9: no new access is started while one is in flight.
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(start_rd || start_wr));
  // R8: an accepted command clears the completion flag.
  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !rd_done);
  // R4: completion appears only at the end of the latency window.
  a_r4_done_at_lat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_done) |-> $past(rd_pipe[RD_LAT-1]));
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phyb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 4,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [PORT_W-1:0] phy_port,
  output logic              phy_wr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_rd,
  input  logic [DATA_W-1:0] phy_rdata
);
  localparam int PORT_LSB = ADDR_W;
  localparam int PORT_MSB = ADDR_W + PORT_W - 1;

  logic              cmd_we, wdata_we;
  logic              start_rd, start_wr, clr_done;
  logic              rd_done, wr_pend, busy;
  logic [DATA_W-1:0] rd_value, payload;
  logic [HOST_W-1:0] cmd_word, wdata_word, rdata_word, stat_word;

  assign wdata_word = {wr_pend, 31'(payload)};
  assign rdata_word = {rd_done, 31'(rd_value)};
  assign stat_word  = {31'b0, busy};

  // The PHY address and data come straight from the stored words. They
  // cannot change during an access because host writes are dropped then.
  assign phy_addr  = cmd_word[ADDR_W-1:0];
  assign phy_port  = cmd_word[PORT_MSB:PORT_LSB];
  assign phy_wdata = payload;

  phyb_host_if u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_sel    (req_sel),
    .cmd_we     (cmd_we),
    .wdata_we   (wdata_we),
    .cmd_word   (cmd_word),
    .wdata_word (wdata_word),
    .rdata_word (rdata_word),
    .stat_word  (stat_word),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  phyb_cmd_regs #(
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .wdata_we   (wdata_we),
    .host_wdata (req_wdata),
    .busy       (busy),
    .cmd_word   (cmd_word),
    .payload    (payload),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .clr_done   (clr_done)
  );

  phyb_xact #(
    .DATA_W (DATA_W),
    .RD_LAT (RD_LAT)
  ) u_xact (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_rd  (start_rd),
    .start_wr  (start_wr),
    .clr_done  (clr_done),
    .phy_rdata (phy_rdata),
    .phy_rd    (phy_rd),
    .phy_wr    (phy_wr),
    .rd_done   (rd_done),
    .rd_value  (rd_value),
    .wr_pend   (wr_pend),
    .busy      (busy)
  );

  // R2: the PHY address and port hold steady while an access is in flight.
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(phy_addr) && $stable(phy_port)));
endmodule

// File: tb/sim_phy_reg_bridge.sv
module sim_phy_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_sel = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [15:0] phy_addr;
  logic [3:0]  phy_port;
  logic        phy_wr;
  logic [15:0] phy_wdata;
  logic        phy_rd;
  logic [15:0] phy_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  logic [31:0] rsp_q[$];
  string       rsp_tag_q[$];
  logic [36:0] phy_q[$];
  string       phy_tag_q[$];

  always #5 clk = ~clk;

  phy_reg_bridge u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .phy_addr  (phy_addr),
    .phy_port  (phy_port),
    .phy_wr    (phy_wr),
    .phy_wdata (phy_wdata),
    .phy_rd    (phy_rd),
    .phy_rdata (phy_rdata)
  );

  // PHY model: 16 registers, data returned two cycles after the strobe cycle,
  // junk outside that cycle. A read returns mem ^ {port, 12'h000}.
  logic [15:0] mem [16];
  logic        s1;
  logic [3:0]  a1;
  logic [3:0]  p1;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'hC000 + 16'(i * 16'h0101);
      s1 <= 1'b0;
      a1 <= 4'd0;
      p1 <= 4'd0;
      phy_rdata <= 16'hDEAD;
    end else begin
      if (phy_wr) mem[phy_addr[3:0]] <= phy_wdata;
      s1 <= phy_rd;
      a1 <= phy_addr[3:0];
      p1 <= phy_port;
      phy_rdata <= s1 ? (mem[a1] ^ {p1, 12'h000}) : 16'hDEAD;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitors.
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (rsp_valid) begin
        if (rsp_q.size() == 0) check(1'b0, "R11 unexpected response", 64'(rsp_data), 64'h0);
        else begin
          automatic logic [31:0] e = rsp_q.pop_front();
          automatic string t = rsp_tag_q.pop_front();
          check(rsp_data == e, t, 64'(rsp_data), 64'(e));
        end
      end
      if (phy_rd || phy_wr) begin
        automatic logic [36:0] got = {phy_rd, phy_addr, phy_port, phy_wr ? phy_wdata : 16'h0};
        if (phy_q.size() == 0) check(1'b0, "R7 R9 R10 unexpected strobe", 64'(got), 64'h0);
        else begin
          automatic logic [36:0] e = phy_q.pop_front();
          automatic string t = phy_tag_q.pop_front();
          check(got == e, t, 64'(got), 64'(e));
        end
      end
    end
  end

  task automatic hwr(input logic [1:0] sel, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] sel, input logic [31:0] e, input string tag);
    rsp_q.push_back(e);
    rsp_tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic exp_phy(input bit rd, input logic [15:0] a, input logic [3:0] p,
                         input logic [15:0] d, input string tag);
    phy_q.push_back({rd, a, p, d});
    phy_tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!rsp_valid && !phy_rd && !phy_wr, "R1 outputs in reset", 64'({rsp_valid, phy_rd, phy_wr}), 64'h0);
    check(req_ready == 1'b1, "R1 R11 ready high", 64'(req_ready), 64'h1);
    rst_n = 1'b1;
    idle(2);
    hrd(2'd0, 32'h0, "R1 cmd word reset");
    hrd(2'd1, 32'h0, "R1 wdata word reset");
    hrd(2'd2, 32'h0, "R1 rdata word reset");
    hrd(2'd3, 32'h0, "R1 status reset");

    // R5/R6: armed write to addr 5 port 3
    hwr(2'd0, 32'h0003_0005);
    exp_phy(1'b0, 16'h0005, 4'h3, 16'hBEEF, "R5 write strobe");
    hwr(2'd1, 32'h8000_BEEF);
    hrd(2'd1, 32'h8000_BEEF, "R6 pending flag set");
    hrd(2'd1, 32'h0000_BEEF, "R6 pending flag cleared");

    // R3/R4: read back addr 5 port 3 -> BEEF ^ 3000 = 8EEF
    exp_phy(1'b1, 16'h0005, 4'h3, 16'h0, "R3 read strobe");
    hwr(2'd0, 32'h0013_0005);
    hrd(2'd2, 32'h0000_0000, "R4 not done one cycle in");
    hrd(2'd3, 32'h0000_0001, "R9 busy during read");
    hrd(2'd2, 32'h0000_0000, "R4 not done at latency edge");
    hrd(2'd2, 32'h8000_8EEF, "R4 data and done");
    hrd(2'd3, 32'h0000_0000, "R9 idle after read");
    hrd(2'd0, 32'h0013_0005, "R2 cmd readback");

    // R8/R10: unknown code clears done, is stored, starts nothing
    hwr(2'd0, 32'h0050_0007);
    hrd(2'd2, 32'h0000_0000, "R8 stale done cleared");
    hrd(2'd0, 32'h0050_0007, "R10 unknown code stored");

    // R10: unknown code cancels an arm
    hwr(2'd0, 32'h0002_0009);
    hwr(2'd0, 32'h7FF2_0009);
    hwr(2'd1, 32'h8000_1234);
    idle(2);
    hrd(2'd1, 32'h0000_1234, "R10 disarmed no pending");

    // R7: flag clear does not launch; one write per arm
    hwr(2'd0, 32'h0001_000A);
    hwr(2'd1, 32'h0000_4321);
    idle(2);
    hrd(2'd1, 32'h0000_4321, "R7 payload stored no launch");
    exp_phy(1'b0, 16'h000A, 4'h1, 16'h5678, "R7 launched write");
    hwr(2'd1, 32'h8000_5678);
    idle(2);
    hwr(2'd1, 32'h8000_9999);
    idle(2);
    hrd(2'd1, 32'h0000_9999, "R7 second write not launched");

    // R9: writes during a read are ignored; addr A port 1 -> 5678 ^ 1000 = 4678
    exp_phy(1'b1, 16'h000A, 4'h1, 16'h0, "R3 read strobe busy test");
    hwr(2'd0, 32'h0011_000A);
    hwr(2'd0, 32'h0004_0002);
    hwr(2'd1, 32'h8000_AAAA);
    hwr(2'd0, 32'h0010_0000);
    hrd(2'd2, 32'h8000_4678, "R9 R4 read unaffected");
    hrd(2'd0, 32'h0011_000A, "R9 cmd unchanged");
    hrd(2'd1, 32'h0000_9999, "R9 wdata unchanged");

    // R4: another pattern, addr 0 port 2 -> C000 ^ 2000 = E000
    exp_phy(1'b1, 16'h0000, 4'h2, 16'h0, "R3 read strobe port 2");
    hwr(2'd0, 32'h0012_0000);
    idle(4);
    hrd(2'd2, 32'h8000_E000, "R4 second pattern");

    // R11: write requests give no response (checked by monitor), then drain
    idle(3);
    check(phy_q.size() == 0, "R3 R5 missing strobes", 64'(phy_q.size()), 64'h0);
    check(rsp_q.size() == 0, "R11 missing responses", 64'(rsp_q.size()), 64'h0);
    finish_run();
  end
endmodule